// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block decides when a plug-in card's two-wire segment, with one data line and one clock line, may be joined to a live backplane segment. It watches an enable pin and a power-good flag. It also watches the sampled logic levels of the data and clock lines on both the card side and the backplane side. From these it drives three outputs: a connect signal that gates the line repeaters, a precharge enable for the line biasing, and a two-bit state code.

After power is present and enable is high, the controller spends a fixed number of cycles initialising with precharge on. It then arms its bus watcher. The segments are joined at the first of two events: all four lines stay high for a full idle interval, or the card-side lines show a stop condition while all four lines are high. Once joined, the link stays up until enable or power is withdrawn. It is not re-qualified while joined.

All pins are plain level control and status signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. The line levels come from analog comparators outside the block and are treated as asynchronous.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `pwr_good_i` is low or reset is asserted, the state is OFF, and `link_o` and `precharge_o` are both low, whatever `en_i` is.
- R2: A low on `en_i` or `pwr_good_i` sends any state to OFF at the next clock edge.
- R3: From OFF with `en_i` and `pwr_good_i` high, the next edge enters INIT. INIT lasts exactly `INIT_CYC` cycles and is followed by WAIT.
- R4: Neither connect condition is evaluated outside WAIT, so idle lines during INIT never cause a connection.
- R5: In WAIT, the link is made once all four synchronized lines have been high for `IDLE_CYC` consecutive cycles.
- R6: A low on any line during WAIT, even for one cycle, restarts the idle count from zero.
- R7: In WAIT, a card-side stop causes a connection on the next edge. A stop is a synchronized card data sample going from 0 to 1 while the card clock is 1 in both samples, with all four lines high now.
- R8: A rising backplane data line while the backplane clock is high is not a stop and does not shorten the idle wait.
- R9: `precharge_o` is high exactly in INIT and WAIT. It falls on the same edge at which `link_o` rises.
- R10: In LINK, the state holds whatever the lines do until `en_i` or `pwr_good_i` falls.
- R11: `state_o` encodes OFF=0, INIT=1, WAIT=2, LINK=3. Each line input passes through a two-flop synchronizer with reset value 1 before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable pin, synchronous level |
| pwr_good_i | input | 1 | Supply-good flag, synchronous level |
| card_sda_i | input | 1 | Card-side data line level (async) |
| card_scl_i | input | 1 | Card-side clock line level (async) |
| bp_sda_i | input | 1 | Backplane data line level (async) |
| bp_scl_i | input | 1 | Backplane clock line level (async) |
| link_o | output | 1 | Connect the repeaters between the segments |
| precharge_o | output | 1 | Enable line precharge bias |
| state_o | output | 2 | Current state code (R11) |

## Verification
The hardest case to reach from the ports is a one-cycle glitch that lands just before the idle count would complete. Because of the synchronizer and the idle counter, the glitch must be placed against an exact edge count. The stimulus lets the count run part way, pulses the backplane clock low for one cycle, and then shows that the link waits a full fresh interval rather than the remaining part. A card-side stop and a backplane-side data rise are each placed early in WAIT. This shows that only the first one short-cuts the idle wait.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  typedef enum logic [1:0] {
    HS_OFF  = 2'd0,
    HS_INIT = 2'd1,
    HS_WAIT = 2'd2,
    HS_LINK = 2'd3
  } hs_state_e;

  localparam int HS_NLINES = 4;

  typedef struct packed {
    logic card_sda;
    logic card_scl;
    logic bp_sda;
    logic bp_scl;
  } hs_lines_t;

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  // Lines idle high, so every stage resets to 1.
  generate
    for (genvar st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[st] <= '1;
          else        chain_q[st] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[st] <= '1;
          else        chain_q[st] <= chain_q[st-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsl_bus_watch.sv
module hsl_bus_watch
  import hsl_pkg::*;
#(
  parameter int IDLE_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_i,
  input  hs_lines_t lines_i,
  output logic      idle_hit_o,
  output logic      stop_hit_o
);
  localparam int CW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic [CW-1:0] idle_cnt_q;
  hs_lines_t     prev_q;
  logic          all_hi;

  assign all_hi = &lines_i;

  // Consecutive all-high cycles seen while armed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idle_cnt_q <= '0;
    else if (!arm_i || !all_hi)  idle_cnt_q <= '0;
    else if (idle_cnt_q != LAST) idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  // Previous synchronized sample, for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lines_i;
  end

  assign idle_hit_o = arm_i && all_hi && (idle_cnt_q == LAST);
  // Card data rising while the card clock stays high, every line high now.
  assign stop_hit_o = arm_i && all_hi && !prev_q.card_sda && prev_q.card_scl;

  // R6: any low line during the armed wait clears the count.
  p_idle_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !all_hi) |=> (idle_cnt_q == '0));

  // R7: a stop needs the card clock high in the previous and current samples.
  p_stop_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit_o |-> ($past(lines_i.card_scl) && lines_i.card_scl));

  // R8: a stop needs the card data low in the previous sample.
  p_stop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit_o |-> !$past(lines_i.card_sda));
endmodule

// File: rtl/hsl_fsm.sv
module hsl_fsm
  import hsl_pkg::*;
#(
  parameter int INIT_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      pwr_i,
  input  logic      idle_hit_i,
  input  logic      stop_hit_i,
  output hs_state_e state_o,
  output logic      arm_o
);
  localparam int CW = (INIT_CYC < 2) ? 1 : $clog2(INIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYC - 1);

  hs_state_e     state_q, state_d;
  logic [CW-1:0] init_cnt_q;
  logic          live;

  assign live = en_i && pwr_i;

  always_comb begin
    state_d = state_q;
    if (!live) begin
      state_d = HS_OFF;
    end else begin
      unique case (state_q)
        HS_OFF:  state_d = HS_INIT;
        HS_INIT: if (init_cnt_q == LAST) state_d = HS_WAIT;
        HS_WAIT: if (idle_hit_i || stop_hit_i) state_d = HS_LINK;
        HS_LINK: state_d = HS_LINK;
        default: state_d = HS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 init_cnt_q <= '0;
    else if (state_q != HS_INIT) init_cnt_q <= '0;
    else if (init_cnt_q != LAST) init_cnt_q <= init_cnt_q + 1'b1;
  end

  assign state_o = state_q;
  assign arm_o   = (state_q == HS_WAIT);

  // R2: losing enable or power always lands in OFF.
  p_drop_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || !pwr_i) |=> (state_q == HS_OFF));

  // R3: WAIT is only entered from INIT.
  p_wait_from_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_WAIT && $past(state_q) != HS_WAIT) |-> ($past(state_q) == HS_INIT));

  // R4: the link is only made from the armed wait.
  p_link_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == HS_LINK) |-> ($past(state_q) == HS_WAIT));

  // R10: the link holds while enable and power stay up.
  p_link_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_LINK && live) |=> (state_q == HS_LINK));
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
  import hsl_pkg::*;
#(
  parameter int INIT_CYC    = 4,
  parameter int IDLE_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       pwr_good_i,
  input  logic       card_sda_i,
  input  logic       card_scl_i,
  input  logic       bp_sda_i,
  input  logic       bp_scl_i,
  output logic       link_o,
  output logic       precharge_o,
  output logic [1:0] state_o
);
  hs_lines_t raw_lines, sync_lines;
  hs_state_e state;
  logic      arm, idle_hit, stop_hit;

  assign raw_lines = '{card_sda: card_sda_i, card_scl: card_scl_i,
                       bp_sda: bp_sda_i, bp_scl: bp_scl_i};

  hsl_sync #(.WIDTH(HS_NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  hsl_bus_watch #(.IDLE_CYC(IDLE_CYC)) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm),
    .lines_i    (sync_lines),
    .idle_hit_o (idle_hit),
    .stop_hit_o (stop_hit)
  );

  hsl_fsm #(.INIT_CYC(INIT_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .pwr_i      (pwr_good_i),
    .idle_hit_i (idle_hit),
    .stop_hit_i (stop_hit),
    .state_o    (state),
    .arm_o      (arm)
  );

  assign state_o     = state;
  assign link_o      = (state == HS_LINK);
  assign precharge_o = (state == HS_INIT) || (state == HS_WAIT);

  // R9: precharge ends by connecting when enable and power stayed up.
  p_prech_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(precharge_o) && $past(en_i) && $past(pwr_good_i)) |-> link_o);

  // R1: with power absent the outputs stay released from the next edge on.
  p_nopwr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> (!link_o && !precharge_o));
endmodule

// File: tb/sim_hotswap_link_ctrl.sv
`timescale 1ns/1ps
module sim_hotswap_link_ctrl;
  localparam int INIT_CYC = 4;
  localparam int IDLE_CYC = 8;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pwr = 1'b1;
  logic csda = 1'b1, cscl = 1'b1, bsda = 1'b1, bscl = 1'b1;
  logic link, prech;
  logic [1:0] st;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hotswap_link_ctrl #(.INIT_CYC(INIT_CYC), .IDLE_CYC(IDLE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pwr_good_i(pwr),
    .card_sda_i(csda), .card_scl_i(cscl), .bp_sda_i(bsda), .bp_scl_i(bscl),
    .link_o(link), .precharge_o(prech), .state_o(st));

  // {en,pwr,card_sda,card_scl,bp_sda,bp_scl}, cycles to wait, expected state
  localparam logic [15:0] VEC [NV] = '{
    {6'b011111, 8'd4,  2'd0},  // R1 R2 off while disabled
    {6'b111111, 8'd1,  2'd1},  // R3 enter INIT
    {6'b111111, 8'd3,  2'd1},  // R4 idle lines ignored in INIT
    {6'b111111, 8'd1,  2'd2},  // R3 INIT_CYC cycles then WAIT
    {6'b111111, 8'd7,  2'd2},  // R5 not yet idle long enough
    {6'b111111, 8'd1,  2'd3},  // R5 R9 idle link
    {6'b110111, 8'd5,  2'd3},  // R10 traffic while linked
    {6'b010111, 8'd1,  2'd0},  // R2 enable drop
    {6'b110111, 8'd1,  2'd1},  // R3
    {6'b110111, 8'd4,  2'd2},  // R3
    {6'b110111, 8'd20, 2'd2},  // R6 data held low, never idle
    {6'b111111, 8'd2,  2'd2},  // R11 synchronizer latency before stop
    {6'b111111, 8'd1,  2'd3},  // R7 card stop links early
    {6'b101111, 8'd1,  2'd0},  // R2 power drop
    {6'b101111, 8'd5,  2'd0},  // R1 no init without power
    {6'b111111, 8'd1,  2'd1},  // R3 power returns
    {6'b111111, 8'd4,  2'd2},  // R3
    {6'b111111, 8'd3,  2'd2},  // R6 partial count
    {6'b111110, 8'd1,  2'd2},  // R6 one-cycle clock glitch
    {6'b111111, 8'd9,  2'd2},  // R6 count restarted
    {6'b111111, 8'd1,  2'd3},  // R6 full fresh interval
    {6'b011111, 8'd1,  2'd0},  // R2
    {6'b111101, 8'd1,  2'd1},  // R3 backplane data low
    {6'b111101, 8'd4,  2'd2},  // R3
    {6'b111111, 8'd3,  2'd2},  // R8 backplane rise is no stop
    {6'b111111, 8'd6,  2'd2},  // R8 still waiting idle
    {6'b111111, 8'd1,  2'd3}   // R5 idle link after backplane rise
  };

  task automatic check(input string req, input logic [1:0] exp_st);
    logic exp_link, exp_pre;
    exp_link = (exp_st == 2'd3);
    exp_pre  = (exp_st == 2'd1) || (exp_st == 2'd2);
    checks += 3;
    if (st !== exp_st) begin
      fails++; $display("FAIL %s state act=%0d exp=%0d", req, st, exp_st);
    end
    if (link !== exp_link) begin
      fails++; $display("FAIL %s link act=%0b exp=%0b", req, link, exp_link);
    end
    if (prech !== exp_pre) begin  // R9 precharge only in INIT/WAIT
      fails++; $display("FAIL %s precharge act=%0b exp=%0b", req, prech, exp_pre);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    en = 1'b1;
    step(3);
    check("R1_reset", 2'd0);       // held in reset even with enable high
    en = 1'b0;
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      {en, pwr, csda, cscl, bsda, bscl} = VEC[i][15:10];
      step(int'(VEC[i][9:2]));
      check($sformatf("vec%0d", i), VEC[i][1:0]);
    end

    // R2 enable drop in the middle of INIT
    en = 1'b0; step(2); check("R2_off", 2'd0);
    en = 1'b1; step(2); check("R2_init", 2'd1);
    en = 1'b0; step(1); check("R2_init_drop", 2'd0);

    // R7 rising card data with clock low is not a stop
    en = 1'b1; csda = 1'b0; cscl = 1'b0;
    step(1 + INIT_CYC); check("R7_wait", 2'd2);
    csda = 1'b1; step(4); check("R7_no_stop_clk_low", 2'd2);
    cscl = 1'b1; step(2 + IDLE_CYC); check("R7_idle_only", 2'd3);

    // R1 reset while linked
    rst_n = 1'b0; step(1); check("R1_reset_link", 2'd0);
    rst_n = 1'b1; step(1); check("R3_after_reset", 2'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule